// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler Taps

This block supervises software by counting slow ticks taken from a free-running prescaler. The ticks come from one of four bits of a main-clock timebase divider, or from one of four bits of a sub-clock watch divider. A 2-bit counter advances on each rising edge of the chosen bit. When that counter overflows, the block raises a one-cycle reset request toward the chip's reset sequencer. Both dividers and the sequencer sit outside the block and arrive as plain inputs.

Software works the block through one 8-bit control register. The first write with the kick bit at 0 arms the watchdog and latches the interval select. Each later such write restarts the count. Once armed, only the core reset can disarm the watchdog. Entry into any low-power or standby state also restarts the count, so a sleeping chip is not reset. The same register reports why the chip last reset: power-on, watchdog, external pin or software. Reading the register clears those flags.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, no reset request is raised and the watchdog is idle. The register reads 0x44: power-on flag bit 6 = 1, kick bit 2 reads as 1, interval select bits 1:0 = 0, all other bits 0.
- R2: A register write with bit 2 = 0 arms the watchdog and latches bits 1:0 as the interval select. Before the first such write, no number of ticks produces a reset request.
- R3: Timebase interval selects 0, 1, 2 and 3 count rising edges of timebase divider bits 12, 14, 16 and 18. Edges on any other bit are not counted.
- R4: Watch divider bits 10, 13, 14 and 15 (for selects 0 to 3) are used only when the watch-source select and the sub-clock-active input are both 1. Otherwise the timebase bits are used.
- R5: After the watchdog is armed or cleared, the 4th counted tick raises `wdg_rst_o` for exactly one clock, and the first 3 ticks raise nothing. A counted tick is a rising edge of the selected bit, seen through a two-stage synchroniser.
- R6: Each write with bit 2 = 0 after arming clears the counter. The select bits of such a write are ignored. A write with bit 2 = 1 has no effect.
- R7: A strobe on any of the five mode-entry inputs clears the counter. When a clear and a counted tick fall in the same cycle, the clear wins.
- R8: Once armed, the watchdog keeps counting across its own reset requests. Only the core reset `rst_n` disarms it.
- R9: Flag bit 5 is set when the reset request fires. Bit 4 is set by the external-cause input and bit 3 by the software-cause input. Bit 6 is set by the power-on reset. A register read clears all flags, but a flag set in the same cycle as a read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low; also resets the cause flags |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe; clears the flags |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register contents |
| tb_taps_i | input | TB_W | Timebase divider bits |
| wt_taps_i | input | WT_W | Watch divider bits |
| watch_src_i | input | 1 | Request watch divider as tick source |
| sub_clk_i | input | 1 | Sub clock is the active system clock |
| mode_entry_i | input | MODE_N | Strobes for watch, timebase, sleep, hold and stop entry |
| ext_cause_i | input | 1 | External reset cause strobe |
| sw_cause_i | input | 1 | Software reset cause strobe |
| wdg_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Two same-cycle collisions need checking. The first is a counted tick meeting a counter clear. With the counter at 3, the bench raises a tap bit and asserts a mode-entry strobe exactly two edges later, in the cycle the synchronised tick is live. The clear must win: no request may follow, and four fresh ticks must then be needed. The second collision is a register read in the very cycle the overflow fires. A second read must still show the watchdog flag set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTL_W   = 8;
  localparam int SEL_LSB = 0;
  localparam int KICK_BIT = 2;
  localparam int SW_BIT  = 3;
  localparam int EXT_BIT = 4;
  localparam int WDG_BIT = 5;
  localparam int POR_BIT = 6;

  typedef logic [1:0] wsel_t;

  typedef struct packed {
    logic por;
    logic wdg;
    logic ext;
    logic sw;
  } cause_t;

  // timebase divider bit chosen by the interval select
  function automatic int tb_tap_idx(input wsel_t s);
    case (s)
      2'd0:    return 12;
      2'd1:    return 14;
      2'd2:    return 16;
      default: return 18;
    endcase
  endfunction

  // watch divider bit chosen by the interval select
  function automatic int wt_tap_idx(input wsel_t s);
    case (s)
      2'd0:    return 10;
      2'd1:    return 13;
      2'd2:    return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/wdog_tap_sel.sv
module wdog_tap_sel
  import wdog_pkg::*;
#(
  parameter int TB_W   = 19,
  parameter int WT_W   = 16,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tb_taps,
  input  logic [WT_W-1:0] wt_taps,
  input  logic            use_watch,
  input  wsel_t           sel,
  output logic            tick
);
  localparam int LAST = SYNC_N - 1;

  logic              raw;
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    if (use_watch) raw = wt_taps[wt_tap_idx(sel)];
    else           raw = tb_taps[tb_tap_idx(sel)];
  end

  generate
    if (SYNC_N > 1) begin : g_chain
      always_comb sync_d = {sync_q[SYNC_N-2:0], raw};
    end else begin : g_single
      always_comb sync_d = raw;
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign tick = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ext_cause,
  input  logic             sw_cause,
  input  logic             ovf,
  output logic             started,
  output wsel_t            sel,
  output logic             kick,
  output logic [CTL_W-1:0] rdata
);
  logic   started_q, started_d;
  wsel_t  sel_q, sel_d;
  cause_t flags_q, flags_d;
  logic   unused_wdata;

  assign unused_wdata = ^{wdata[CTL_W-1:KICK_BIT+1]};
  assign kick = wr_en & ~wdata[KICK_BIT];

  always_comb begin
    started_d = started_q | kick;
    sel_d     = sel_q;
    if (kick && !started_q) sel_d = wdata[SEL_LSB +: 2];
  end

  // a set in the same cycle as a read survives the read
  always_comb begin
    flags_d.por = flags_q.por & ~rd_en;
    flags_d.wdg = ovf       | (flags_q.wdg & ~rd_en);
    flags_d.ext = ext_cause | (flags_q.ext & ~rd_en);
    flags_d.sw  = sw_cause  | (flags_q.sw  & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      started_q <= started_d;
      sel_q     <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags_q <= '{por: 1'b1, wdg: 1'b0, ext: 1'b0, sw: 1'b0};
    end else begin
      flags_q <= flags_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[SEL_LSB +: 2]    = sel_q;
    rdata[KICK_BIT]        = 1'b1;
    rdata[SW_BIT]          = flags_q.sw;
    rdata[EXT_BIT]         = flags_q.ext;
    rdata[WDG_BIT]         = flags_q.wdg;
    rdata[POR_BIT]         = flags_q.por;
  end

  assign started = started_q;
  assign sel     = sel_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             adv;

  assign adv = run & tick & ~clr;
  assign ovf = adv & (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
    pulse_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt       = cnt_q;
  assign rst_pulse = pulse_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TB_W   = 19,
  parameter int WT_W   = 16,
  parameter int MODE_N = 5,
  parameter int CNT_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [CTL_W-1:0]  reg_wdata_i,
  output logic [CTL_W-1:0]  reg_rdata_o,
  input  logic [TB_W-1:0]   tb_taps_i,
  input  logic [WT_W-1:0]   wt_taps_i,
  input  logic              watch_src_i,
  input  logic              sub_clk_i,
  input  logic [MODE_N-1:0] mode_entry_i,
  input  logic              ext_cause_i,
  input  logic              sw_cause_i,
  output logic              wdg_rst_o
);
  logic             started, kick, tick, ovf, clr, use_watch;
  wsel_t            sel;
  logic [CNT_W-1:0] cnt;

  assign use_watch = watch_src_i & sub_clk_i;
  assign clr       = kick | (|mode_entry_i);

  wdog_tap_sel #(.TB_W(TB_W), .WT_W(WT_W), .SYNC_N(SYNC_N)) u_tap (
    .clk(clk), .rst_n(rst_n), .tb_taps(tb_taps_i), .wt_taps(wt_taps_i),
    .use_watch(use_watch), .sel(sel), .tick(tick)
  );

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(reg_wr_i), .rd_en(reg_rd_i),
    .wdata(reg_wdata_i), .ext_cause(ext_cause_i), .sw_cause(sw_cause_i),
    .ovf(ovf), .started(started), .sel(sel), .kick(kick), .rdata(reg_rdata_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(started), .tick(tick), .clr(clr),
    .ovf(ovf), .cnt(cnt), .rst_pulse(wdg_rst_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W  = 2,
  parameter int MODE_N = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             wdg_rst_o,
  input logic             started,
  input logic             kick,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       sel,
  input logic [MODE_N-1:0] mode,
  input logic             wdg_flag
);
  // R5
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_o |=> !wdg_rst_o);
  // R2
  idle_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !wdg_rst_o);
  // R8
  stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started);
  // R6
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0) && !wdg_rst_o);
  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mode) |=> (cnt == '0) && !wdg_rst_o);
  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> $stable(sel));
  // R9
  flag_on_rst_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(wdg_rst_o) |-> wdg_flag);
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W), .MODE_N(MODE_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .wdg_rst_o(wdg_rst_o),
  .started(started), .kick(kick), .cnt(cnt), .sel(sel),
  .mode(mode_entry_i), .wdg_flag(reg_rdata_o[wdog_pkg::WDG_BIT])
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  logic        clk = 1'b0;
  logic        rst_n, por_n, reg_wr, reg_rd;
  logic [7:0]  wdata, rdata;
  logic [18:0] tb_taps;
  logic [15:0] wt_taps;
  logic        watch_src, sub_clk, ext_c, sw_c, wdg_rst;
  logic [4:0]  mode;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tb_taps_i(tb_taps), .wt_taps_i(wt_taps),
    .watch_src_i(watch_src), .sub_clk_i(sub_clk), .mode_entry_i(mode),
    .ext_cause_i(ext_c), .sw_cause_i(sw_c), .wdg_rst_o(wdg_rst)
  );

  always @(negedge clk) if (wdg_rst === 1'b1) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic por_reset();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic core_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input bit watch, input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (watch) wt_taps[b] = 1'b1; else tb_taps[b] = 1'b1;
      repeat (4) @(negedge clk);
      if (watch) wt_taps[b] = 1'b0; else tb_taps[b] = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  function automatic int tb_bit(input int s);
    return (s == 0) ? 12 : (s == 1) ? 14 : (s == 2) ? 16 : 18;
  endfunction

  function automatic int wt_bit(input int s);
    return (s == 0) ? 10 : (s == 1) ? 13 : (s == 2) ? 14 : 15;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    por_reset();
    chk("R1 no request after reset", pulses, 0);
    rd(d);
    chk("R1 register after reset", d, 8'h44);
    rd(d);
    chk("R9 power-on flag cleared by read", d[6], 0);
  endtask

  task automatic t_prestart();
    int p0 = pulses;
    ticks(1'b0, 12, 8);
    chk("R2 no request before arming", pulses - p0, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    int p0;
    wr(8'h00);
    p0 = pulses;
    ticks(1'b0, 12, 3);
    chk("R5 no request after three ticks", pulses - p0, 0);
    ticks(1'b0, 12, 1);
    chk("R5 one-cycle request on fourth tick", pulses - p0, 1);
    rd(d);
    chk("R9 watchdog flag set", d[5], 1);
  endtask

  task automatic t_sel();
    logic [7:0] d;
    int p0;
    for (int s = 1; s < 4; s++) begin
      core_reset();
      wr(8'(s));
      rd(d);
      chk("R2 select latched", d[1:0], s);
      p0 = pulses;
      ticks(1'b0, tb_bit(s - 1), 8);
      chk("R3 other tap ignored", pulses - p0, 0);
      ticks(1'b0, tb_bit(s), 4);
      chk("R3 selected timebase tap", pulses - p0, 1);
    end
  endtask

  task automatic t_watch();
    int p0;
    watch_src = 1'b1; sub_clk = 1'b1;
    for (int s = 0; s < 4; s++) begin
      core_reset();
      wr(8'(s));
      p0 = pulses;
      ticks(1'b0, tb_bit(s), 4);
      chk("R4 timebase ignored in watch source", pulses - p0, 0);
      ticks(1'b1, wt_bit(s), 4);
      chk("R4 selected watch tap", pulses - p0, 1);
    end
    sub_clk = 1'b0;
    core_reset();
    wr(8'h01);
    p0 = pulses;
    ticks(1'b1, 13, 4);
    chk("R4 watch tap unused on main clock", pulses - p0, 0);
    ticks(1'b0, 14, 4);
    chk("R4 timebase tap on main clock", pulses - p0, 1);
    watch_src = 1'b0;
  endtask

  task automatic t_kick();
    logic [7:0] d;
    int p0;
    core_reset();
    wr(8'h00);
    p0 = pulses;
    ticks(1'b0, 12, 3);
    wr(8'h03);
    ticks(1'b0, 12, 3);
    chk("R6 kick clears counter", pulses - p0, 0);
    rd(d);
    chk("R6 select ignored after arming", d[1:0], 0);
    wr(8'h04);
    ticks(1'b0, 12, 1);
    chk("R6 write with bit2 set is no kick", pulses - p0, 1);
    ticks(1'b0, 12, 4);
    chk("R8 keeps running after request", pulses - p0, 2);
    core_reset();
    p0 = pulses;
    ticks(1'b0, 12, 6);
    chk("R8 core reset disarms", pulses - p0, 0);
  endtask

  task automatic t_mode();
    int p0;
    for (int m = 0; m < 5; m++) begin
      core_reset();
      wr(8'h00);
      p0 = pulses;
      ticks(1'b0, 12, 3);
      @(negedge clk); mode[m] = 1'b1;
      @(negedge clk); mode[m] = 1'b0;
      ticks(1'b0, 12, 3);
      chk("R7 mode strobe clears", pulses - p0, 0);
      ticks(1'b0, 12, 1);
      chk("R7 count resumes after mode", pulses - p0, 1);
    end
    // collision: strobe in the cycle the synchronised tick is live
    core_reset();
    wr(8'h00);
    p0 = pulses;
    ticks(1'b0, 12, 3);
    @(negedge clk); tb_taps[12] = 1'b1;
    repeat (2) @(negedge clk);
    mode[2] = 1'b1;
    @(negedge clk); mode[2] = 1'b0;
    repeat (2) @(negedge clk); tb_taps[12] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 clear beats tick", pulses - p0, 0);
    ticks(1'b0, 12, 3);
    chk("R7 full four ticks after collision", pulses - p0, 0);
    ticks(1'b0, 12, 1);
    chk("R7 request after collision", pulses - p0, 1);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    rd(d);
    @(negedge clk); ext_c = 1'b1;
    @(negedge clk); ext_c = 1'b0;
    rd(d);
    chk("R9 external flag", d[4], 1);
    chk("R9 software flag clear", d[3], 0);
    @(negedge clk); sw_c = 1'b1;
    @(negedge clk); sw_c = 1'b0;
    rd(d);
    chk("R9 software flag", d[3], 1);
    chk("R9 external flag cleared", d[4], 0);
    // read colliding with the overflow edge
    core_reset();
    wr(8'h00);
    rd(d);
    ticks(1'b0, 12, 3);
    @(negedge clk); tb_taps[12] = 1'b1;
    repeat (2) @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    repeat (2) @(negedge clk); tb_taps[12] = 1'b0;
    repeat (4) @(negedge clk);
    rd(d);
    chk("R9 set wins over same-cycle read", d[5], 1);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; wdata = '0;
    tb_taps = '0; wt_taps = '0; watch_src = 1'b0; sub_clk = 1'b0;
    mode = '0; ext_c = 1'b0; sw_c = 1'b0;
    t_reset();
    t_prestart();
    t_timeout();
    t_sel();
    t_watch();
    t_kick();
    t_mode();
    t_flags();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule